// File: doc/BRIEF.md
# Bus-Master DMA Front End for a Crypto Engine

This block lets a crypto engine move data between system memory and its internal buffers as an AHB bus master. The engine hands over one request at a time: a byte start address, a byte count and a direction. The block then asks the arbiter for the bus and walks the range with single non-sequential transfers. Each transfer is a 32-bit word when the address is word aligned and at least four bytes remain, and a single byte otherwise. It surrounds every request with idle cycles, so two requests never run back to back on the bus.

Two configuration inputs are captured when a request is accepted. One holds the bus locked for the whole request, so that its transfers cannot be split by another master. The other marks the bus as big-endian and byte-swaps every word between the bus lanes and the engine's little-endian data. The engine supplies write data and receives read data through a strobe that fires as each data phase completes. A one-cycle done pulse, with an error flag beside it, closes every request.

Top module: `ahb_dma_master`

## Requirements
- R1: While reset is held and in the first cycle after it, HTRANS is IDLE (2'b00), hbusreq, hlock, done and eng_xfer are low, and req_ready is high.
- R2: A request with a length of zero produces done high (with done_err low) in the cycle after acceptance, and hbusreq is never raised for it.
- R3: Each transfer is NONSEQ (2'b10) at the current address. HSIZE is word (3'b010) when address bits [1:0] are 0 and at least 4 bytes remain, and byte (3'b000) otherwise. The address then advances by 4 or by 1.
- R4: The cycle after acceptance always shows IDLE. When hgrant and hready are both high at that point, the first NONSEQ follows in the next cycle, so exactly one leading IDLE is seen.
- R5: hbusreq is high from the cycle after acceptance until the final address phase is shown while hgrant is high. It is low in that cycle and stays low until the next request.
- R6: After the final address phase is accepted, HTRANS stays IDLE until done, so every request ends with an IDLE transfer.
- R7: While HREADY is low, a pending NONSEQ keeps its address and size, and no further address phase is taken.
- R8: When the lock bit was set at acceptance, hlock is high from the cycle after acceptance through the last address phase, and low for the trailing IDLE.
- R9: When the big-endian bit was set at acceptance, HWDATA is the byte-swapped engine word and eng_rdata is the byte-swapped HRDATA. When it was clear, both pass through unchanged.
- R10: Changes to the lock and endian inputs after acceptance have no effect on the request in progress.
- R11: eng_xfer pulses in every cycle where a data phase completes with HREADY high and HRESP OKAY (2'b00). eng_addr, eng_word and eng_write describe that phase. done pulses for one cycle in the cycle after the final data phase completes.
- R12: An HRESP of ERROR (2'b01) with HREADY high in a data phase stops all further NONSEQ transfers and ends the request with done and done_err high together.
- R13: HTRANS is NONSEQ only in cycles where hgrant is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lock_en | input | 1 | Lock the bus for the whole request (captured at acceptance) |
| cfg_big_end | input | 1 | Bus is big-endian; byte-swap words (captured at acceptance) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is free; request accepted when both are high |
| req_addr | input | AW | Byte start address |
| req_len | input | LW | Byte count |
| req_write | input | 1 | 1 = write to memory, 0 = read from memory |
| done | output | 1 | One-cycle request completion pulse |
| done_err | output | 1 | Valid with done; request ended by a bus error |
| eng_xfer | output | 1 | Data phase completed this cycle |
| eng_write | output | 1 | Current data phase is a write |
| eng_word | output | 1 | Current data phase is a word transfer |
| eng_addr | output | AW | Address of the current data phase |
| eng_wdata | input | 32 | Engine write data for the current data phase, little-endian lanes |
| eng_rdata | output | 32 | Read data converted to little-endian lanes |
| hbusreq | output | 1 | Bus request to the arbiter |
| hgrant | input | 1 | Bus granted |
| hlock | output | 1 | Locked sequence |
| htrans | output | 2 | Transfer type |
| hsize | output | 3 | Transfer size |
| haddr | output | AW | Transfer address |
| hwdata | output | 32 | Write data |
| hrdata | input | 32 | Read data |
| hready | input | 1 | Transfer done / stall |
| hresp | input | 2 | Transfer response |

## Verification
Word-aligned lengths with a grant that is always high and no wait states isolate the leading-IDLE count and the exact cycle in which the bus request drops. Odd start addresses and odd lengths force byte, word and byte mixes, which separate the size rule from plain address stepping. A random grant and random wait states show whether address and control are held during a stall and whether a lost grant is re-requested. Each request also toggles the lock and endian inputs after acceptance, which tells a design that captures them from one that follows the live pins. An injected error response shows whether the block aborts the request and raises the error flag.

// File: rtl/ahb_dma_pkg.sv
package ahb_dma_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_NONSEQ = 2'b10
    } htrans_e;

    localparam logic [2:0] SZ_BYTE = 3'b000;
    localparam logic [2:0] SZ_WORD = 3'b010;

    localparam logic [1:0] RESP_OKAY = 2'b00;
    localparam logic [1:0] RESP_ERR  = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_XFER,
        ST_TAIL
    } dma_state_e;

    typedef struct packed {
        logic valid;
        logic write;
        logic word;
    } dphase_t;

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W / 8; i++) begin
            r[8*i +: 8] = w[DATA_W - 8*(i+1) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ahb_dma_agen.sv
module ahb_dma_agen
    import ahb_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          clear,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    output logic [AW-1:0] cur_addr,
    output logic          use_word,
    output logic          is_last
);
    localparam logic [LW-1:0] WORD_BYTES = LW'(DATA_W / 8);
    localparam logic [LW-1:0] ONE_BYTE   = LW'(1);

    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [LW-1:0] step_len;

    always_comb begin
        use_word = (addr_q[1:0] == 2'b00) && (rem_q >= WORD_BYTES);
        step_len = use_word ? WORD_BYTES : ONE_BYTE;
        is_last  = (rem_q == step_len);
        cur_addr = addr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            addr_q <= ld_addr;
            rem_q  <= ld_len;
        end else if (clear) begin
            rem_q  <= '0;
        end else if (step) begin
            addr_q <= addr_q + AW'(step_len);
            rem_q  <= rem_q - step_len;
        end
    end

    // R3: a step is only ever taken while bytes remain to cover it
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
        step |-> (rem_q >= step_len));

endmodule

// File: rtl/ahb_dma_ctrl.sv
module ahb_dma_ctrl
    import ahb_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_len_zero,
    input  logic       req_write,
    input  logic       cfg_lock_en,
    input  logic       cfg_big_end,
    input  logic       hgrant,
    input  logic       hready,
    input  logic [1:0] hresp,
    input  logic       dp_valid,
    input  logic       is_last,
    output logic       req_ready,
    output logic       load,
    output logic       issue,
    output logic       step,
    output logic       clear,
    output logic       wr_q,
    output logic       big_q,
    output logic       hbusreq,
    output logic       hlock,
    output logic       done,
    output logic       done_err
);
    dma_state_e st_q;
    logic       lock_q, err_q;
    logic       accept, resp_ok, resp_err, abort, tail_fin, active;

    always_comb begin
        req_ready = (st_q == ST_IDLE);
        accept    = req_valid && req_ready;
        load      = accept && !req_len_zero;
        resp_ok   = (hresp == RESP_OKAY);
        resp_err  = (hresp == RESP_ERR);
        issue     = (st_q == ST_XFER) && hgrant && resp_ok;
        step      = issue && hready;
        abort     = (st_q == ST_XFER) && dp_valid && hready && resp_err;
        clear     = abort;
        tail_fin  = (st_q == ST_TAIL) && (!dp_valid || hready);
        active    = (st_q == ST_ARB) || (st_q == ST_XFER);
        hbusreq   = (st_q == ST_ARB) || ((st_q == ST_XFER) && !(is_last && hgrant));
        hlock     = lock_q && active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            lock_q   <= 1'b0;
            big_q    <= 1'b0;
            wr_q     <= 1'b0;
            err_q    <= 1'b0;
            done     <= 1'b0;
            done_err <= 1'b0;
        end else begin
            done     <= (accept && req_len_zero) || tail_fin;
            done_err <= tail_fin && (err_q || (dp_valid && resp_err));
            unique case (st_q)
                ST_IDLE: if (load) begin
                    st_q   <= ST_ARB;
                    lock_q <= cfg_lock_en;
                    big_q  <= cfg_big_end;
                    wr_q   <= req_write;
                    err_q  <= 1'b0;
                end
                ST_ARB: if (hgrant && hready) st_q <= ST_XFER;
                ST_XFER: begin
                    if (abort) begin
                        err_q <= 1'b1;
                        st_q  <= ST_TAIL;
                    end else if (step && is_last) begin
                        st_q  <= ST_TAIL;
                    end
                end
                ST_TAIL: if (tail_fin) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R2: an empty request never reaches the arbiter
    assert_empty_no_busreq_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && req_len_zero) |=> !hbusreq);

    // R4: the cycle after acceptance is never a real transfer
    assert_lead_idle_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> !issue);

    // R12: an error response ends the stream of transfers
    assert_err_stops_R12: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!issue && !hlock));

endmodule

// File: rtl/ahb_dma_dphase.sv
module ahb_dma_dphase
    import ahb_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hready,
    input  logic [1:0]        hresp,
    input  logic              issue,
    input  logic              wr,
    input  logic              big,
    input  logic              use_word,
    input  logic [AW-1:0]     cur_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic [DATA_W-1:0] hrdata,
    output logic              dp_valid,
    output logic              eng_xfer,
    output logic              eng_write,
    output logic              eng_word,
    output logic [AW-1:0]     eng_addr,
    output logic [DATA_W-1:0] eng_rdata,
    output logic [DATA_W-1:0] hwdata
);
    dphase_t       dp_q;
    logic [AW-1:0] dp_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q      <= '0;
            dp_addr_q <= '0;
        end else if (hready) begin
            dp_q.valid <= issue;
            dp_q.write <= wr;
            dp_q.word  <= use_word;
            dp_addr_q  <= cur_addr;
        end
    end

    always_comb begin
        dp_valid  = dp_q.valid;
        eng_xfer  = dp_q.valid && hready && (hresp == RESP_OKAY);
        eng_write = dp_q.write;
        eng_word  = dp_q.word;
        eng_addr  = dp_addr_q;
        eng_rdata = big ? swap_bytes(hrdata) : hrdata;
        if (dp_q.valid && dp_q.write)
            hwdata = big ? swap_bytes(eng_wdata) : eng_wdata;
        else
            hwdata = '0;
    end

    // R11: a data phase only exists after an address phase was taken
    assert_dphase_origin_R11: assert property (@(posedge clk) disable iff (rst)
        (hready && !issue) |=> !dp_valid);

endmodule

// File: rtl/ahb_dma_master.sv
module ahb_dma_master
    import ahb_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_lock_en,
    input  logic              cfg_big_end,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [LW-1:0]     req_len,
    input  logic              req_write,
    output logic              done,
    output logic              done_err,
    output logic              eng_xfer,
    output logic              eng_write,
    output logic              eng_word,
    output logic [AW-1:0]     eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] eng_rdata,
    output logic              hbusreq,
    input  logic              hgrant,
    output logic              hlock,
    output logic [1:0]        htrans,
    output logic [2:0]        hsize,
    output logic [AW-1:0]     haddr,
    output logic [DATA_W-1:0] hwdata,
    input  logic [DATA_W-1:0] hrdata,
    input  logic              hready,
    input  logic [1:0]        hresp
);
    logic          load, issue, step, clear, wr_q, big_q;
    logic          dp_valid, use_word, is_last;
    logic [AW-1:0] cur_addr;

    ahb_dma_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_len_zero (req_len == '0),
        .req_write    (req_write),
        .cfg_lock_en  (cfg_lock_en),
        .cfg_big_end  (cfg_big_end),
        .hgrant       (hgrant),
        .hready       (hready),
        .hresp        (hresp),
        .dp_valid     (dp_valid),
        .is_last      (is_last),
        .req_ready    (req_ready),
        .load         (load),
        .issue        (issue),
        .step         (step),
        .clear        (clear),
        .wr_q         (wr_q),
        .big_q        (big_q),
        .hbusreq      (hbusreq),
        .hlock        (hlock),
        .done         (done),
        .done_err     (done_err)
    );

    ahb_dma_agen #(.AW(AW), .LW(LW)) u_agen (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .clear    (clear),
        .ld_addr  (req_addr),
        .ld_len   (req_len),
        .cur_addr (cur_addr),
        .use_word (use_word),
        .is_last  (is_last)
    );

    ahb_dma_dphase #(.AW(AW)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .hready    (hready),
        .hresp     (hresp),
        .issue     (issue),
        .wr        (wr_q),
        .big       (big_q),
        .use_word  (use_word),
        .cur_addr  (cur_addr),
        .eng_wdata (eng_wdata),
        .hrdata    (hrdata),
        .dp_valid  (dp_valid),
        .eng_xfer  (eng_xfer),
        .eng_write (eng_write),
        .eng_word  (eng_word),
        .eng_addr  (eng_addr),
        .eng_rdata (eng_rdata),
        .hwdata    (hwdata)
    );

    always_comb begin
        htrans = issue ? TR_NONSEQ : TR_IDLE;
        hsize  = (issue && use_word) ? SZ_WORD : SZ_BYTE;
        haddr  = cur_addr;
    end

    // R7: a stalled address phase keeps its address and size
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (htrans == TR_NONSEQ && !hready) |=>
        (!hgrant || hresp != RESP_OKAY ||
         (htrans == TR_NONSEQ && $stable(haddr) && $stable(hsize))));

    // R3: a word transfer is always word aligned
    assert_size_align_R3: assert property (@(posedge clk) disable iff (rst)
        (htrans == TR_NONSEQ && hsize == SZ_WORD) |-> (haddr[1:0] == 2'b00));

    // R13: no transfer without ownership
    assert_grant_needed_R13: assert property (@(posedge clk) disable iff (rst)
        (htrans == TR_NONSEQ) |-> hgrant);

    // R6: the cycle of a done pulse is never a transfer and holds no request
    assert_tail_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (htrans == TR_IDLE && !hbusreq && !hlock));

endmodule

// File: tb/sim_ahb_dma_master.sv
module sim_ahb_dma_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_lock_en = 1'b0, cfg_big_end = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        req_ready, done, done_err, eng_xfer, eng_write, eng_word;
    logic [31:0] eng_addr, eng_wdata, eng_rdata;
    logic        hbusreq, hlock;
    logic        hgrant = 1'b1, hready = 1'b1;
    logic [1:0]  htrans, hresp = 2'b00;
    logic [2:0]  hsize;
    logic [31:0] haddr, hwdata, hrdata = '0;

    int total = 0, bad = 0, cyc = 0;
    int gmode = 0, rmode = 0;
    bit err_on = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        logic [7:0] b;
        b = {a[7:2], 2'b00};
        return {b + 8'd3, b + 8'd2, b + 8'd1, b};
    endfunction

    function automatic logic [31:0] bsw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    assign eng_wdata = pat(eng_addr);

    ahb_dma_master u0 (
        .clk(clk), .rst(rst), .cfg_lock_en(cfg_lock_en), .cfg_big_end(cfg_big_end),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_write(req_write), .done(done), .done_err(done_err),
        .eng_xfer(eng_xfer), .eng_write(eng_write), .eng_word(eng_word),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .hbusreq(hbusreq), .hgrant(hgrant), .hlock(hlock), .htrans(htrans),
        .hsize(hsize), .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata),
        .hready(hready), .hresp(hresp)
    );

    // behavioural reference state
    int          m_st = 0, m_rem = 0;
    logic [31:0] m_addr = '0, m_dpa = '0;
    bit          m_wr, m_lock, m_big, m_err, m_dpv, m_dpw, m_dpword, m_done, m_derr;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // bus-side stimulus
    always @(negedge clk) begin
        case (gmode)
            0: hgrant = 1'b1;
            1: hgrant = ($urandom % 4) != 0;
            default: hgrant = 1'b0;
        endcase
        hready = (rmode == 0) ? 1'b1 : (($urandom % 3) != 0);
        hrdata = $urandom;
        hresp  = (err_on && m_dpv) ? 2'b01 : 2'b00;
    end

    // reference model, one step per clock
    always @(posedge clk) begin
        bit wd, iss;
        int sz;
        logic [31:0] oa;
        if (rst) begin
            m_st = 0; m_rem = 0; m_addr = '0; m_dpv = 0; m_dpa = '0;
            m_done = 0; m_derr = 0; m_err = 0; m_lock = 0; m_big = 0; m_wr = 0;
            m_dpw = 0; m_dpword = 0;
        end else begin
            wd  = (m_addr[1:0] == 2'b00) && (m_rem >= 4);
            sz  = wd ? 4 : 1;
            iss = (m_st == 2) && hgrant && (hresp == 2'b00);
            oa  = m_addr;
            m_done = 0; m_derr = 0;
            case (m_st)
                0: if (req_valid) begin
                    if (req_len == 0) m_done = 1;
                    else begin
                        m_addr = req_addr; m_rem = int'(req_len); m_wr = req_write;
                        m_lock = cfg_lock_en; m_big = cfg_big_end; m_err = 0; m_st = 1;
                    end
                end
                1: if (hgrant && hready) m_st = 2;
                2: if (m_dpv && hready && hresp == 2'b01) begin
                    m_err = 1; m_rem = 0; m_st = 3;
                end else if (iss && hready) begin
                    m_addr = m_addr + sz; m_rem = m_rem - sz;
                    if (m_rem == 0) m_st = 3;
                end
                default: if (!m_dpv || hready) begin
                    m_done = 1; m_derr = m_err || (m_dpv && hresp == 2'b01); m_st = 0;
                end
            endcase
            if (hready) begin
                m_dpv = iss; m_dpa = oa; m_dpword = wd; m_dpw = m_wr;
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        bit wd, lst, iss, ebr, exf;
        int sz;
        #1;
        if (!rst) begin
            wd  = (m_addr[1:0] == 2'b00) && (m_rem >= 4);
            sz  = wd ? 4 : 1;
            lst = (m_rem == sz);
            iss = (m_st == 2) && hgrant && (hresp == 2'b00);
            ebr = (m_st == 1) || ((m_st == 2) && !(lst && hgrant));
            exf = m_dpv && hready && (hresp == 2'b00);
            check(req_ready == (m_st == 0), "R1 req_ready", 32'(req_ready), 32'(m_st == 0));
            check(htrans == (iss ? 2'b10 : 2'b00), "R4/R6/R13 htrans", 32'(htrans),
                  32'(iss ? 2'b10 : 2'b00));
            if (iss) begin
                check(haddr == m_addr, "R3/R7 haddr", haddr, m_addr);
                check(hsize == (wd ? 3'b010 : 3'b000), "R3 hsize", 32'(hsize),
                      32'(wd ? 3'b010 : 3'b000));
            end
            check(hbusreq == ebr, "R5 hbusreq", 32'(hbusreq), 32'(ebr));
            check(hlock == (m_lock && (m_st == 1 || m_st == 2)), "R8/R10 hlock",
                  32'(hlock), 32'(m_lock && (m_st == 1 || m_st == 2)));
            check(done == m_done, "R11 done", 32'(done), 32'(m_done));
            if (m_done) check(done_err == m_derr, "R12 done_err", 32'(done_err), 32'(m_derr));
            check(eng_xfer == exf, "R11 eng_xfer", 32'(eng_xfer), 32'(exf));
            if (exf) begin
                check(eng_addr == m_dpa, "R11 eng_addr", eng_addr, m_dpa);
                check(eng_word == m_dpword, "R3 eng_word", 32'(eng_word), 32'(m_dpword));
                check(eng_write == m_dpw, "R11 eng_write", 32'(eng_write), 32'(m_dpw));
                if (!m_dpw)
                    check(eng_rdata == (m_big ? bsw(hrdata) : hrdata), "R9/R10 eng_rdata",
                          eng_rdata, m_big ? bsw(hrdata) : hrdata);
            end
            if (m_dpv && m_dpw)
                check(hwdata == (m_big ? bsw(pat(m_dpa)) : pat(m_dpa)), "R9/R10 hwdata",
                      hwdata, m_big ? bsw(pat(m_dpa)) : pat(m_dpa));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_req(input logic [31:0] a, input int len, input bit wr,
                          input bit lk, input bit be);
        int n;
        @(negedge clk);
        while (m_st != 0) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 16'(len); req_write = wr;
        cfg_lock_en = lk; cfg_big_end = be;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_lock_en = !lk; cfg_big_end = !be;   // R10: late changes must not matter
        n = 0;
        while (!m_done && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(htrans == 2'b00 && !hbusreq && !hlock && !done && req_ready,
              "R1 reset state", {htrans, hbusreq, hlock, done, req_ready}, 32'h1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(htrans == 2'b00 && !hbusreq && !done && !eng_xfer && req_ready,
              "R1 after reset", {htrans, hbusreq, done, eng_xfer, req_ready}, 32'h1);

        // R2: empty request
        @(negedge clk);
        req_valid = 1'b1; req_len = 16'd0; req_addr = 32'h55;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(done && !done_err && !hbusreq, "R2 zero length",
              {done, done_err, hbusreq}, 32'h4);

        // R4: exactly one leading IDLE with grant already held
        gmode = 0; rmode = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h100; req_len = 16'd8; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(htrans == 2'b00, "R4 leading idle", 32'(htrans), 32'h0);
        @(negedge clk);
        #1;
        check(htrans == 2'b10, "R4 first transfer", 32'(htrans), 32'h2);
        while (!m_done) @(negedge clk);

        gmode = 1; rmode = 1;
        do_req(32'h203, 10, 1'b0, 1'b0, 1'b0);
        do_req(32'h301, 9, 1'b1, 1'b0, 1'b1);
        do_req(32'h400, 12, 1'b0, 1'b1, 1'b1);
        do_req(32'h502, 7, 1'b1, 1'b1, 1'b0);

        // R12: error response aborts
        err_on = 1'b1;
        do_req(32'h600, 16, 1'b1, 1'b1, 1'b0);
        #1;
        check(done && done_err, "R12 abort flagged", {done, done_err}, 32'h3);
        err_on = 1'b0;

        for (int i = 0; i < 40; i++) begin
            gmode = $urandom % 2; rmode = $urandom % 2;
            do_req(32'h1000 + ($urandom % 64), $urandom % 13, $urandom % 2,
                   $urandom % 2, $urandom % 2);
        end
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule